// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the bus latching logic of a byte-wide nonvolatile memory and sees one qualified write cycle at a time, each with an address and a data byte. It recognises the three-cycle and six-cycle unlock command sequences. From these it starts page loads and chip erases, sets and clears a global write-protect flag, and enters and leaves an identification mode. Write cycles that belong to no sequence are treated as plain data writes. Such a write is either accepted into the page being loaded or refused, depending on protection and on whether a page-load window is open.

Every command outcome appears as a registered output in the cycle after the write that completed it. When a protected plain write is refused, the decoder reports it with a one-cycle pulse. It then ignores all write cycles for a fixed number of clock cycles. While identification mode is active, the read side returns the maker code or the device code for the two lowest addresses. The page buffer, the array and the timing of the physical bus are outside this block.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, prot_on, id_mode and locked are 0, and none of load_open, load_byte, erase_start or write_blocked is asserted.
- R2: The writes AAh at address 5555h, then 55h at 2AAAh, then A0h at 5555h set prot_on. They also pulse load_open for one cycle, in the cycle after the third write. None of the three cycles pulses load_byte. This holds whether or not prot_on was already set.
- R3: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h pulse erase_start for exactly one cycle, in the cycle after the sixth write.
- R4: The same six-write prefix ending in 20h@5555h clears prot_on.
- R5: id_mode is set by the three-write sequence ending in 90h@5555h and also by the six-write sequence ending in 60h@5555h. It is cleared by the three-write sequence ending in F0h@5555h.
- R6: id_hit is 1 only when id_mode is 1 and rd_addr bits 14..1 are all zero. id_data is then BFh for rd_addr bit 0 = 0 and 5Dh for bit 0 = 1. Otherwise id_hit is 0 and id_data is 00h.
- R7: When prot_on is 0 and no page-load window is open, a plain write pulses both load_open and load_byte in the next cycle.
- R8: When prot_on is 1 and no page-load window is open, a plain write pulses write_blocked and does not pulse load_byte. locked then stays 1 for LOCK_CYCLES cycles.
- R9: Every write cycle presented while locked is 1 is ignored, including sequence steps. Such a write causes no pulse, no change of prot_on or id_mode, and no progress of the sequence matcher.
- R10: A load_open or load_byte pulse opens a page-load window of LOAD_WIN cycles. A plain write inside the window pulses load_byte without load_open, even when prot_on is 1. Each accepted byte restarts the window.
- R11: A write that is not the expected next step returns the matcher to idle. The same write is then judged as a possible first step (AAh@5555h) or, failing that, as a plain write.
- R12: Only address bits 14..0 take part in sequence matching. Bit 15 of wr_addr and of rd_addr is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A latched bus write is present this cycle |
| wr_addr | input | AW | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_addr | input | AW | Address of a read, used for identification data |
| load_open | output | 1 | Pulse: a page load was opened |
| load_byte | output | 1 | Pulse: a data byte was accepted into the page |
| erase_start | output | 1 | Pulse: chip erase requested |
| prot_on | output | 1 | Global write protection is set |
| id_mode | output | 1 | Identification mode is active |
| write_blocked | output | 1 | Pulse: a protected plain write was refused |
| locked | output | 1 | Post-refusal lockout in progress |
| id_hit | output | 1 | rd_addr selects an identification byte |
| id_data | output | 8 | Identification byte, 00h when id_hit is 0 |

## Verification
The bench first targets a sequence that is broken by a repeated AAh@5555h. A matcher that simply drops to idle would miss the restart and never reach identification mode. It then sends a full unlock sequence during the lockout. A design that still let sequence steps through would clear protection there. Plain writes land one cycle inside and one cycle outside the page-load window while protection is set. An off-by-one window would accept a byte that should have been refused, or refuse one that should have been accepted. Address bit 15 is set on sequence steps and on identification reads, so a full-width comparison would fail to match or return no hit.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned CMP_W  = 15;

  localparam logic [CMP_W-1:0]  ADDR_LO = 15'h5555;
  localparam logic [CMP_W-1:0]  ADDR_HI = 15'h2AAA;
  localparam logic [DATA_W-1:0] KEY_A   = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_B   = 8'h55;
  localparam logic [DATA_W-1:0] OP_WRITE = 8'hA0;
  localparam logic [DATA_W-1:0] OP_IDON  = 8'h90;
  localparam logic [DATA_W-1:0] OP_IDOFF = 8'hF0;
  localparam logic [DATA_W-1:0] OP_LONG  = 8'h80;
  localparam logic [DATA_W-1:0] OP_ERASE = 8'h10;
  localparam logic [DATA_W-1:0] OP_UNPROT = 8'h20;
  localparam logic [DATA_W-1:0] OP_IDALT = 8'h60;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_DATA,
    CMD_UNLOCK_WR,
    CMD_ID_ON,
    CMD_ID_OFF,
    CMD_ERASE,
    CMD_PROT_OFF
  } ucd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_X3,
    ST_X4,
    ST_X5
  } ucd_step_e;

endpackage

// File: rtl/ucd_rst_sync.sv
module ucd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ucd_seq_match.sv
module ucd_seq_match
  import ucd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMP_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ucd_cmd_e          cmd
);
  ucd_step_e st_q, st_d;
  logic      at_lo, at_hi, is_first;

  always_comb begin
    at_lo    = (wr_addr == ADDR_LO);
    at_hi    = (wr_addr == ADDR_HI);
    is_first = at_lo && (wr_data == KEY_A);
    st_d     = st_q;
    cmd      = CMD_NONE;
    if (wr_en) begin
      // default: leave the sequence, judge this cycle afresh
      st_d = is_first ? ST_K1 : ST_IDLE;
      cmd  = is_first ? CMD_NONE : CMD_DATA;
      case (st_q)
        ST_K1, ST_X4: begin
          if (at_hi && wr_data == KEY_B) begin
            st_d = (st_q == ST_K1) ? ST_K2 : ST_X5;
            cmd  = CMD_NONE;
          end
        end
        ST_K2: begin
          if (at_lo) begin
            case (wr_data)
              OP_WRITE: begin st_d = ST_IDLE; cmd = CMD_UNLOCK_WR; end
              OP_IDON:  begin st_d = ST_IDLE; cmd = CMD_ID_ON;     end
              OP_IDOFF: begin st_d = ST_IDLE; cmd = CMD_ID_OFF;    end
              OP_LONG:  begin st_d = ST_X3;   cmd = CMD_NONE;      end
              default:  ;
            endcase
          end
        end
        ST_X3: begin
          if (is_first) st_d = ST_X4;
        end
        ST_X5: begin
          if (at_lo) begin
            case (wr_data)
              OP_ERASE:  begin st_d = ST_IDLE; cmd = CMD_ERASE;    end
              OP_UNPROT: begin st_d = ST_IDLE; cmd = CMD_PROT_OFF; end
              OP_IDALT:  begin st_d = ST_IDLE; cmd = CMD_ID_ON;    end
              default:   ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else if (wr_en) st_q <= st_d;
  end

  // R2: the third step is only reachable from the second step
  a_r2_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_K2) |-> ($past(st_q) == ST_K1 || $past(st_q) == ST_K2));

  // R9: with writes gated off the matcher holds its step
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(st_q));

endmodule

// File: rtl/ucd_guard.sv
module ucd_guard
  import ucd_pkg::*;
#(
  parameter int unsigned LOAD_WIN    = 16,
  parameter int unsigned LOCK_CYCLES = 24
) (
  input  logic     clk,
  input  logic     rst_n,
  input  ucd_cmd_e cmd,
  output logic     prot_on,
  output logic     id_mode,
  output logic     locked,
  output logic     load_open,
  output logic     load_byte,
  output logic     erase_start,
  output logic     write_blocked
);
  localparam int unsigned WIN_W = $clog2(LOAD_WIN + 1);
  localparam int unsigned LK_W  = $clog2(LOCK_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_FULL  = WIN_W'(LOAD_WIN);
  localparam logic [LK_W-1:0]  LOCK_FULL = LK_W'(LOCK_CYCLES);

  logic [WIN_W-1:0] win_q, win_d;
  logic [LK_W-1:0]  lock_q, lock_d;
  logic prot_q, prot_d, id_q, id_d;
  logic open_q, open_d, byte_q, byte_d, erase_q, erase_d, blk_q, blk_d;
  logic win_live;

  always_comb begin
    win_live = (win_q != '0);
    prot_d   = prot_q;
    id_d     = id_q;
    open_d   = 1'b0;
    byte_d   = 1'b0;
    erase_d  = 1'b0;
    blk_d    = 1'b0;
    win_d    = win_live ? win_q - 1'b1 : '0;
    lock_d   = (lock_q != '0) ? lock_q - 1'b1 : '0;
    case (cmd)
      CMD_DATA: begin
        if (win_live) begin
          byte_d = 1'b1;
          win_d  = WIN_FULL;
        end else if (!prot_q) begin
          open_d = 1'b1;
          byte_d = 1'b1;
          win_d  = WIN_FULL;
        end else begin
          blk_d  = 1'b1;
          lock_d = LOCK_FULL;
        end
      end
      CMD_UNLOCK_WR: begin
        prot_d = 1'b1;
        open_d = 1'b1;
        win_d  = WIN_FULL;
      end
      CMD_ID_ON:    id_d    = 1'b1;
      CMD_ID_OFF:   id_d    = 1'b0;
      CMD_ERASE:    erase_d = 1'b1;
      CMD_PROT_OFF: prot_d  = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      lock_q  <= '0;
      prot_q  <= 1'b0;
      id_q    <= 1'b0;
      open_q  <= 1'b0;
      byte_q  <= 1'b0;
      erase_q <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      win_q   <= win_d;
      lock_q  <= lock_d;
      prot_q  <= prot_d;
      id_q    <= id_d;
      open_q  <= open_d;
      byte_q  <= byte_d;
      erase_q <= erase_d;
      blk_q   <= blk_d;
    end
  end

  assign prot_on       = prot_q;
  assign id_mode       = id_q;
  assign locked        = (lock_q != '0);
  assign load_open     = open_q;
  assign load_byte     = byte_q;
  assign erase_start   = erase_q;
  assign write_blocked = blk_q;

  // R8: a refusal only happens with protection set, and starts the lockout
  a_r8_blocked_when_protected: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> (prot_on && locked));

  // R9: no event comes out of a cycle spent locked
  a_r9_quiet_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cmd == CMD_NONE) |=> !(load_open || load_byte || erase_start || write_blocked));

  // R3: at most one kind of event per cycle
  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_open, erase_start, write_blocked}));

  // R7: opening a page load from a plain write also takes its byte
  a_r7_open_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DATA && !prot_on && !win_live) |=> (load_open && load_byte));

endmodule

// File: rtl/ucd_id_port.sv
module ucd_id_port
  import ucd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MAKER_ID  = 8'hBF,
  parameter logic [DATA_W-1:0] DEVICE_ID = 8'h5D
) (
  input  logic              id_mode,
  input  logic [CMP_W-1:0]  rd_addr,
  output logic              id_hit,
  output logic [DATA_W-1:0] id_data
);
  always_comb begin
    id_hit  = id_mode && (rd_addr[CMP_W-1:1] == '0);
    id_data = '0;
    if (id_hit) id_data = rd_addr[0] ? DEVICE_ID : MAKER_ID;
  end
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned LOAD_WIN    = 16,
  parameter int unsigned LOCK_CYCLES = 24,
  parameter logic [7:0]  MAKER_ID    = 8'hBF,
  parameter logic [7:0]  DEVICE_ID   = 8'h5D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic          load_open,
  output logic          load_byte,
  output logic          erase_start,
  output logic          prot_on,
  output logic          id_mode,
  output logic          write_blocked,
  output logic          locked,
  output logic          id_hit,
  output logic [7:0]    id_data
);
  logic     rst_n_i;
  logic     wr_en;
  ucd_cmd_e cmd;
  logic     unused_high;

  // R12: bits above the compared field take no part
  assign unused_high = ^{wr_addr[AW-1:CMP_W], rd_addr[AW-1:CMP_W]};

  ucd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // R9: writes are dropped for the whole lockout
  assign wr_en = wr_valid && !locked;

  ucd_seq_match u_match (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr[CMP_W-1:0]),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  ucd_guard #(
    .LOAD_WIN    (LOAD_WIN),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_guard (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .cmd           (cmd),
    .prot_on       (prot_on),
    .id_mode       (id_mode),
    .locked        (locked),
    .load_open     (load_open),
    .load_byte     (load_byte),
    .erase_start   (erase_start),
    .write_blocked (write_blocked)
  );

  ucd_id_port #(
    .MAKER_ID  (MAKER_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_id (
    .id_mode (id_mode),
    .rd_addr (rd_addr[CMP_W-1:0]),
    .id_hit  (id_hit),
    .id_data (id_data)
  );

  // R6: an identification byte is only ever one of the two codes
  a_r6_id_value: assert property (@(posedge clk) disable iff (!rst_n_i)
    id_hit |-> (id_mode && (id_data == MAKER_ID || id_data == DEVICE_ID)));

  // R5: identification mode changes only in response to a write
  a_r5_id_needs_write: assert property (@(posedge clk) disable iff (!rst_n_i)
    !wr_en |=> $stable(id_mode));

endmodule

// File: tb/sim_unlock_cmd_decoder.sv
`timescale 1ns/1ps
module sim_unlock_cmd_decoder;
  localparam int WIN  = 16;
  localparam int LOCK = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] rd_addr;
  logic load_open, load_byte, erase_start, prot_on, id_mode, write_blocked, locked, id_hit;
  logic [7:0] id_data;

  int checks = 0;
  int fails  = 0;

  int m_st, m_win, m_lock;
  bit m_prot, m_id;
  bit e_open, e_byte, e_erase, e_blk;

  always #5 clk = ~clk;

  unlock_cmd_decoder #(.AW(16), .LOAD_WIN(WIN), .LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .load_open(load_open), .load_byte(load_byte), .erase_start(erase_start),
    .prot_on(prot_on), .id_mode(id_mode), .write_blocked(write_blocked), .locked(locked),
    .id_hit(id_hit), .id_data(id_data));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(bit v, logic [15:0] a, logic [7:0] d);
    logic [14:0] a15;
    bit first;
    int cmd, nst;
    bit win_was;
    a15 = a[14:0];
    cmd = 0;
    e_open = 0; e_byte = 0; e_erase = 0; e_blk = 0;
    if (v && m_lock == 0) begin
      first = (a15 == 15'h5555) && (d == 8'hAA);
      nst = first ? 1 : 0;
      cmd = first ? 0 : 1;
      case (m_st)
        1, 4: if (a15 == 15'h2AAA && d == 8'h55) begin nst = m_st + 1; cmd = 0; end
        2: if (a15 == 15'h5555) begin
             if (d == 8'hA0) begin nst = 0; cmd = 2; end
             else if (d == 8'h90) begin nst = 0; cmd = 3; end
             else if (d == 8'hF0) begin nst = 0; cmd = 4; end
             else if (d == 8'h80) begin nst = 3; cmd = 0; end
           end
        3: if (first) nst = 4;
        5: if (a15 == 15'h5555) begin
             if (d == 8'h10) begin nst = 0; cmd = 5; end
             else if (d == 8'h20) begin nst = 0; cmd = 6; end
             else if (d == 8'h60) begin nst = 0; cmd = 3; end
           end
        default: ;
      endcase
      m_st = nst;
    end
    win_was = (m_win != 0);
    m_win  = (m_win  != 0) ? m_win - 1 : 0;
    m_lock = (m_lock != 0) ? m_lock - 1 : 0;
    case (cmd)
      1: begin
        if (win_was) begin e_byte = 1; m_win = WIN; end
        else if (!m_prot) begin e_open = 1; e_byte = 1; m_win = WIN; end
        else begin e_blk = 1; m_lock = LOCK; end
      end
      2: begin m_prot = 1; e_open = 1; m_win = WIN; end
      3: m_id = 1;
      4: m_id = 0;
      5: e_erase = 1;
      6: m_prot = 0;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] id_exp(logic [15:0] a);
    if (m_id && a[14:1] == 14'd0) return a[0] ? 8'h5D : 8'hBF;
    return 8'h00;
  endfunction

  // one bus cycle: drive at negedge, check the registered result one negedge later
  task automatic cyc(bit v, logic [15:0] a, logic [7:0] d);
    wr_valid = v; wr_addr = a; wr_data = d;
    model_step(v, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R7 load_open", load_open, e_open);
    chk("R10 load_byte", load_byte, e_byte);
    chk("R3 erase_start", erase_start, e_erase);
    chk("R4 prot_on", prot_on, m_prot);
    chk("R5 id_mode", id_mode, m_id);
    chk("R8 write_blocked", write_blocked, e_blk);
    chk("R9 locked", locked, m_lock != 0);
    chk("R6 id_hit", id_hit, id_exp(rd_addr) != 8'h00);
    chk("R6 id_data", id_data, id_exp(rd_addr));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 16'h0, 8'h0);
  endtask

  task automatic seq3(logic [7:0] op);
    cyc(1, 16'hD555, 8'hAA);
    cyc(1, 16'h2AAA, 8'h55);
    cyc(1, 16'h5555, op);
  endtask

  task automatic seq6(logic [7:0] op);
    seq3(8'h80);
    cyc(1, 16'h5555, 8'hAA);
    cyc(1, 16'hAAAA, 8'h55);
    cyc(1, 16'h5555, op);
  endtask

  task automatic rd_check(logic [15:0] a, bit hit, logic [7:0] d);
    rd_addr = a;
    #1;
    chk("R6 id_hit read", id_hit, hit);
    chk("R6 id_data read", id_data, d);
    rd_addr = 16'h1234;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_win = 0; m_lock = 0; m_prot = 0; m_id = 0;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 prot_on", prot_on, 0);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 locked", locked, 0);
    chk("R1 pulses", {load_open, load_byte, erase_start, write_blocked}, 0);

    // R7 unprotected plain write opens a load
    cyc(1, 16'h0123, 8'h11);
    chk("R7 open", load_open, 1);
    chk("R7 byte", load_byte, 1);
    idle(WIN + 2);

    // R2 + R12 unlock write with bit 15 set on steps
    cyc(1, 16'hD555, 8'hAA);
    chk("R2 no byte on step", load_byte, 0);
    cyc(1, 16'hAAAA, 8'h55);
    cyc(1, 16'hD555, 8'hA0);
    chk("R12 open via high-bit address", load_open, 1);
    chk("R2 prot set", prot_on, 1);
    chk("R2 no byte on opcode", load_byte, 0);

    // R10 byte inside the window while protected
    cyc(1, 16'h0200, 8'h33);
    chk("R10 byte accepted", load_byte, 1);
    chk("R10 no reopen", load_open, 0);
    idle(WIN - 1);
    cyc(1, 16'h0201, 8'h34);
    chk("R10 last window cycle", load_byte, 1);
    idle(WIN);

    // R8 protected write outside window
    cyc(1, 16'h0300, 8'h44);
    chk("R8 blocked", write_blocked, 1);
    chk("R8 no byte", load_byte, 0);
    chk("R8 locked", locked, 1);

    // R9 sequence during lockout is ignored
    seq6(8'h20);
    chk("R9 prot kept", prot_on, 1);
    idle(LOCK);
    chk("R9 lock over", locked, 0);

    // R4 clear protection
    seq6(8'h20);
    chk("R4 prot cleared", prot_on, 0);

    // R11 restart on repeated first step
    cyc(1, 16'h5555, 8'hAA);
    cyc(1, 16'h5555, 8'hAA);
    chk("R11 no data from restart", load_byte, 0);
    cyc(1, 16'h2AAA, 8'h55);
    cyc(1, 16'h5555, 8'h90);
    chk("R11 id entered", id_mode, 1);

    // R6 reads
    rd_check(16'h0000, 1, 8'hBF);
    rd_check(16'h0001, 1, 8'h5D);
    rd_check(16'h8000, 1, 8'hBF);
    rd_check(16'h0002, 0, 8'h00);

    // R5 exit, alternate entry, exit
    seq3(8'hF0);
    chk("R5 exit", id_mode, 0);
    seq6(8'h60);
    chk("R5 alt entry", id_mode, 1);
    seq3(8'hF0);
    chk("R5 exit again", id_mode, 0);

    // R3 erase pulse of one cycle
    seq6(8'h10);
    chk("R3 erase pulse", erase_start, 1);
    idle(1);
    chk("R3 erase ends", erase_start, 0);

    // random mix
    for (int op = 0; op < 900; op++) begin
      int r;
      r = $urandom % 10;
      rd_addr = ($urandom % 2) ? {15'($urandom % 2) , 14'd0, 1'($urandom % 2)} : 16'($urandom);
      if (r < 4) begin
        logic [7:0] ops [6];
        logic [7:0] dat [6];
        logic [15:0] adr [6];
        int k, n, bad;
        ops = '{8'hA0, 8'h90, 8'hF0, 8'h10, 8'h20, 8'h60};
        k = $urandom % 6;
        n = (k < 3) ? 3 : 6;
        adr = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
        dat = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h00};
        if (n == 3) dat[2] = ops[k]; else dat[5] = ops[k];
        bad = (($urandom % 4) == 0) ? ($urandom % n) : -1;
        for (int s = 0; s < n; s++) begin
          logic [7:0] dd;
          dd = (s == bad) ? 8'($urandom) : dat[s];
          cyc(1, adr[s] | {1'($urandom % 2), 15'd0}, dd);
          if (($urandom % 4) == 0) idle(1);
        end
      end else if (r < 8) begin
        cyc(1, 16'($urandom), 8'($urandom));
      end else begin
        idle(1 + $urandom % 30);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule